// File: doc/BRIEF.md
# Memory-Device Boundary-Scan Test Access Port

This block is the serial test port of a memory device. It runs the standard sixteen-state test controller on TCK and TMS. It holds a three-bit instruction register and three data paths: a one-bit bypass stage, a 32-bit identification word, and a 109-bit boundary chain that captures the device pins in parallel.

Two instructions capture the pins while telling the pad ring to float the data pins: the external-test code and a non-standard sample-with-float code. The ordinary sample code leaves the data pins alone. There is no separate test-reset pin, so the power-on reset puts the port into Test-Logic-Reset.

TMS and TDI are expected to carry pull-ups at the pads, so an undriven line reads as 1. TDO is produced as a value plus an output enable, and the pad combines the two into a three-state driver.

Top module: `mem_tap_port`

## Requirements
- R1: When por_n is low at a rising TCK edge, or after five consecutive rising edges with TMS high, the controller is in Test-Logic-Reset. The active instruction then becomes IDCODE (001), so dq_hiz is low and a data shift returns the identification word.
- R2: The controller follows the sixteen standard states, with TMS sampled on rising TCK. Leaving Shift-DR through Exit1, Pause and Exit2 and returning to Shift-DR resumes the shift without a new capture.
- R3: The instruction register is 3 bits wide. Capture-IR loads 3'b001 (bit 0 = 1, bits 2:1 = 0). Bits shift out least significant first while TDI enters the top bit. The shifted value becomes the active instruction on the rising edge that leaves Update-IR.
- R4: The instruction codes are:
  - 000 external test, using the boundary chain;
  - 001 IDCODE, using the identification register;
  - 010 sample with data pins floated, using the boundary chain;
  - 100 sample, using the boundary chain;
  - 111 BYPASS, using the bypass stage.
  - The reserved codes 011, 101 and 110 also select the bypass stage.
- R5: dq_hiz is high exactly while the active instruction is 000 or 010. It changes only after Update-IR, Test-Logic-Reset or power-on reset.
- R6: The identification word is 32'h0268019D, made up as follows:
  - bits 31:29 hold the revision, 000;
  - bits 28:12 hold the configuration field 00,ddd,0,ww,0,t,0,q,0,b,0,s,0, with density 010, width 11, DLL flag t=1, and q, b and s all 0;
  - bits 11:1 hold the manufacturer code 00011001110;
  - bit 0 is always 1.
  The word shifts out least significant first and is exactly 32 bits long.
- R7: The bypass stage captures 0 at Capture-DR and delays TDI by one stage. It keeps the last bit shifted in across Pause-DR.
- R8: The boundary chain is 109 bits long. At Capture-DR, bit i loads pin_capture[i]. Bit 0 is the first bit out on TDO, and TDI enters bit 108.
- R9: TDO and tdo_oe are updated on falling TCK and hold their values across the following rising edge. tdo_oe is high only in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in, sampled on rising TCK |
| pin_capture | input | 109 | Parallel pin values loaded into the boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_oe | output | 1 | Drive enable for the TDO pad |
| dq_hiz | output | 1 | Request to float the device data pins |

## Verification
The bench builds the port with its default parameters: a 109-bit boundary chain and a 36 Mb, x36, DLL-equipped, double-rate, two-beat, common-I/O identification word. These defaults allow the full chain to be shifted end to end and then pushed through a second time after a pause, which proves its exact length. They also allow the identification word to be compared against an independently composed 32-bit constant. Every defined and reserved instruction is loaded at least once. The bench also checks that dq_hiz follows the active instruction and that the instruction falls back to IDCODE, both after five TMS-high edges and after a power-on reset.

// File: rtl/memtap_pkg.sv
// Package memtap_pkg
// Shared types for the memory test access port. It holds the controller
// state encoding, the instruction codes, the data-path selector and a
// function that builds the identification word from configuration flags.
package memtap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_EXIT2_DR = 4'h0,
        ST_EXIT1_DR = 4'h1,
        ST_SHIFT_DR = 4'h2,
        ST_PAUSE_DR = 4'h3,
        ST_SEL_IR   = 4'h4,
        ST_UPD_DR   = 4'h5,
        ST_CAP_DR   = 4'h6,
        ST_SEL_DR   = 4'h7,
        ST_EXIT2_IR = 4'h8,
        ST_EXIT1_IR = 4'h9,
        ST_SHIFT_IR = 4'hA,
        ST_PAUSE_IR = 4'hB,
        ST_IDLE     = 4'hC,
        ST_UPD_IR   = 4'hD,
        ST_CAP_IR   = 4'hE,
        ST_RESET    = 4'hF
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;

    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        DR_BYPASS   = 2'd0,
        DR_IDENT    = 2'd1,
        DR_BOUNDARY = 2'd2
    } dr_sel_e;

    // Assemble the identification word from the device configuration flags.
    function automatic logic [ID_W-1:0] make_idcode(
        input logic [2:0]  rev,
        input logic [2:0]  dens,
        input logic [1:0]  width,
        input logic        dll,
        input logic        qdr,
        input logic        burst4,
        input logic        sep_io,
        input logic [10:0] mfg
    );
        logic [16:0] cfg;
        cfg = {2'b00, dens, 1'b0, width, 1'b0, dll, 1'b0, qdr,
               1'b0, burst4, 1'b0, sep_io, 1'b0};
        return {rev, cfg, mfg, 1'b1};
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Module tap_fsm
// The sixteen-state test controller. TMS is sampled on rising TCK. A low
// por_n forces Test-Logic-Reset, and so do five TMS-high edges.
// Assumes TMS carries a pad pull-up, so an undriven line reads as 1.
module tap_fsm
    import memtap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    localparam int RESET_RUN = 5;
    localparam int CNT_W     = $clog2(RESET_RUN + 1);

    tap_state_e           state_nx;
    logic [CNT_W-1:0]     ones_cnt;

    // Next-state function of the controller.
    always_comb begin
        case (state)
            ST_RESET:    state_nx = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_nx = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_nx = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_nx = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: state_nx = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: state_nx = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_nx = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: state_nx = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   state_nx = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_nx = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_nx = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: state_nx = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: state_nx = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_nx = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: state_nx = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   state_nx = tms ? ST_SEL_DR   : ST_IDLE;
            default:     state_nx = ST_RESET;
        endcase
    end

    // State register with the power-on reset.
    always_ff @(posedge tck) begin
        if (!por_n) begin
            state <= ST_RESET;
        end else begin
            state <= state_nx;
        end
    end

    // Checker counter: length of the current run of TMS-high edges, saturating.
    always_ff @(posedge tck) begin
        if (!por_n || !tms) begin
            ones_cnt <= '0;
        end else if (ones_cnt != CNT_W'(RESET_RUN)) begin
            ones_cnt <= ones_cnt + CNT_W'(1);
        end
    end

    // R1: five TMS-high edges always land in Test-Logic-Reset.
    assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!por_n)
        (ones_cnt == CNT_W'(RESET_RUN)) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
// Module tap_ir
// The instruction register: a capture/shift stage and the active
// instruction. The active instruction loads on the edge that leaves
// Update-IR and falls back to IDCODE in Test-Logic-Reset.
module tap_ir
    import memtap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_tdo,
    output logic [IR_W-1:0] instr
);

    logic [IR_W-1:0] ir_sr;

    // Capture the fixed pattern, or shift toward TDO least significant first.
    always_ff @(posedge tck) begin
        if (!por_n) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == ST_CAP_IR) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == ST_SHIFT_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    // Active instruction: IDCODE on reset, shifted value on Update-IR.
    always_ff @(posedge tck) begin
        if (!por_n || state == ST_RESET) begin
            instr <= OP_IDCODE;
        end else if (state == ST_UPD_IR) begin
            instr <= ir_sr;
        end
    end

    assign ir_tdo = ir_sr[0];

    // R3: after Capture-IR the stage holds the fixed pattern.
    assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_IR) |=> (ir_tdo == IR_CAPTURE[0]));

    // R3: the instruction taken at Update-IR is the value that was shifted in.
    assert_ir_update_R3: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_UPD_IR) |=> (instr == $past(ir_sr)));

endmodule

// File: rtl/tap_dr.sv
// Module tap_dr
// The data registers: the bypass stage, the identification word and the
// boundary chain. Only the register picked by sel captures or shifts, and
// its bit 0 feeds dr_tdo.
module tap_dr
    import memtap_pkg::*;
#(
    parameter int              BSR_LEN  = 109,
    parameter logic [ID_W-1:0] ID_VALUE = '1
) (
    input  logic               tck,
    input  logic               por_n,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins,
    output logic               dr_tdo
);

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;
    logic [BSR_LEN-1:0] bsr_shift;
    logic               cap;
    logic               shf;

    assign cap = (state == ST_CAP_DR);
    assign shf = (state == ST_SHIFT_DR);

    // The chain-length parameter picks the form of the shifted value.
    generate
        if (BSR_LEN == 1) begin : g_bsr_single
            assign bsr_shift = tdi;
        end else begin : g_bsr_chain
            assign bsr_shift = {tdi, bsr_q[BSR_LEN-1:1]};
        end
    endgenerate

    // Bypass stage: cleared at capture, takes TDI while shifting.
    always_ff @(posedge tck) begin
        if (!por_n) begin
            byp_q <= 1'b0;
        end else if (sel == DR_BYPASS && cap) begin
            byp_q <= 1'b0;
        end else if (sel == DR_BYPASS && shf) begin
            byp_q <= tdi;
        end
    end

    // Identification register: loads the constant word, then shifts.
    always_ff @(posedge tck) begin
        if (!por_n) begin
            id_q <= ID_VALUE;
        end else if (sel == DR_IDENT && cap) begin
            id_q <= ID_VALUE;
        end else if (sel == DR_IDENT && shf) begin
            id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    // Boundary chain: parallel pin capture, then serial shift.
    always_ff @(posedge tck) begin
        if (!por_n) begin
            bsr_q <= '0;
        end else if (sel == DR_BOUNDARY && cap) begin
            bsr_q <= pins;
        end else if (sel == DR_BOUNDARY && shf) begin
            bsr_q <= bsr_shift;
        end
    end

    // Serial output of whichever register is selected.
    always_comb begin
        case (sel)
            DR_IDENT:    dr_tdo = id_q[0];
            DR_BOUNDARY: dr_tdo = bsr_q[0];
            default:     dr_tdo = byp_q;
        endcase
    end

    // R7: the bypass stage presents 0 after capture.
    assert_bypass_capture_R7: assert property (@(posedge tck) disable iff (!por_n)
        (cap && sel == DR_BYPASS) |=> (dr_tdo == 1'b0));

    // R6: the identification word always presents a 1 first.
    assert_ident_lsb_R6: assert property (@(posedge tck) disable iff (!por_n)
        (cap && sel == DR_IDENT) |=> (dr_tdo == 1'b1));

    // R8: TDI enters the far end of the boundary chain.
    assert_bsr_entry_R8: assert property (@(posedge tck) disable iff (!por_n)
        (shf && sel == DR_BOUNDARY) |=> (bsr_q[BSR_LEN-1] == $past(tdi)));

endmodule

// File: rtl/mem_tap_port.sv
// Module mem_tap_port
// Top of the memory test access port. It joins the controller, the
// instruction register and the data registers. It decodes the active
// instruction into a data-path select and the data-pin float request,
// and it drives TDO and its enable from falling TCK.
// Assumes a pad-level three-state buffer combines tdo and tdo_oe, and
// that the pads pull TMS and TDI up.
module mem_tap_port
    import memtap_pkg::*;
#(
    parameter int          BSR_LEN    = 109,
    parameter logic [2:0]  REVISION   = 3'b000,
    parameter logic [2:0]  DENSITY    = 3'b010,
    parameter logic [1:0]  WIDTH_CODE = 2'b11,
    parameter logic        HAS_DLL    = 1'b1,
    parameter logic        QUAD_RATE  = 1'b0,
    parameter logic        BURST4     = 1'b0,
    parameter logic        SPLIT_IO   = 1'b0,
    parameter logic [10:0] MFG_CODE   = 11'b00011001110
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_capture,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               dq_hiz
);

    localparam logic [ID_W-1:0] ID_VALUE = make_idcode(REVISION, DENSITY,
        WIDTH_CODE, HAS_DLL, QUAD_RATE, BURST4, SPLIT_IO, MFG_CODE);

    tap_state_e      state;
    logic [IR_W-1:0] instr;
    logic            ir_tdo;
    logic            dr_tdo;
    dr_sel_e         sel;

    tap_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .por_n  (por_n),
        .state  (state),
        .tdi    (tdi),
        .ir_tdo (ir_tdo),
        .instr  (instr)
    );

    tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck    (tck),
        .por_n  (por_n),
        .state  (state),
        .sel    (sel),
        .tdi    (tdi),
        .pins   (pin_capture),
        .dr_tdo (dr_tdo)
    );

    // Instruction decode: data-path select and the data-pin float request.
    always_comb begin
        case (instr)
            OP_EXTEST:  begin sel = DR_BOUNDARY; dq_hiz = 1'b1; end
            OP_IDCODE:  begin sel = DR_IDENT;    dq_hiz = 1'b0; end
            OP_SAMPLEZ: begin sel = DR_BOUNDARY; dq_hiz = 1'b1; end
            OP_SAMPLE:  begin sel = DR_BOUNDARY; dq_hiz = 1'b0; end
            default:    begin sel = DR_BYPASS;   dq_hiz = 1'b0; end
        endcase
    end

    // TDO value and enable, launched on falling TCK.
    always_ff @(negedge tck) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SHIFT_IR) || (state == ST_SHIFT_DR);
            tdo    <= (state == ST_SHIFT_IR) ? ir_tdo : dr_tdo;
        end
    end

    // R9: the TDO pad is enabled only in a shift state.
    assert_tdo_enable_R9: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == ST_SHIFT_IR || state == ST_SHIFT_DR));

    // R5: the float request moves only after Update-IR, Test-Logic-Reset or power-on reset.
    assert_hiz_change_R5: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(dq_hiz) |-> (!$past(por_n) || $past(state) == ST_UPD_IR
                              || $past(state) == ST_RESET));

endmodule

// File: tb/mem_tap_port_tb.sv
`timescale 1ns/1ps
// Bench for mem_tap_port. Driver tasks walk the controller and push the
// expected TDO bits into a scoreboard queue. A monitor pops one entry on
// every falling edge of a shift and compares it with TDO.
module mem_tap_port_tb;

    localparam int N = 109;

    logic         tck    = 1'b0;
    logic         por_n  = 1'b0;
    logic         tms    = 1'b1;
    logic         tdi    = 1'b1;
    logic [N-1:0] pins   = '0;
    logic         tdo;
    logic         tdo_oe;
    logic         dq_hiz;

    int    checks = 0;
    int    errors = 0;
    bit    mon_en = 1'b0;
    logic  exp_bits[$];
    string exp_tags[$];

    // R6: identification word assembled field by field.
    localparam logic [31:0] ID_EXP = {3'b000, 2'b00, 3'b010, 1'b0, 2'b11, 1'b0,
        1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'b00011001110, 1'b1};

    mem_tap_port u_dut (
        .tck         (tck),
        .por_n       (por_n),
        .tms         (tms),
        .tdi         (tdi),
        .pin_capture (pins),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .dq_hiz      (dq_hiz)
    );

    always #2 tck = ~tck;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: compare TDO against the scoreboard on each falling edge of a shift.
    always @(negedge tck) begin
        if (mon_en) begin
            #1;
            if (exp_bits.size() == 0) begin
                check("R2 scoreboard underrun", 1, 0);
            end else begin
                check(exp_tags.pop_front(), {31'b0, tdo}, {31'b0, exp_bits.pop_front()});
                check("R9 tdo_oe in shift", {31'b0, tdo_oe}, 32'd1);
            end
        end
    end

    task automatic tick(input logic tms_v, input logic tdi_v);
        tms = tms_v;
        tdi = tdi_v;
        @(posedge tck);
        #1;
    endtask

    task automatic tap_reset();
        por_n = 1'b0;
        repeat (3) tick(1'b1, 1'b1);
        por_n = 1'b1;
    endtask

    // From Idle: load an instruction, expecting the captured pattern on TDO.
    task automatic shift_ir(input logic [2:0] code, input string tag);
        tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
        for (int i = 0; i < 3; i++) begin
            exp_bits.push_back((i == 0) ? 1'b1 : 1'b0);
            exp_tags.push_back(tag);
        end
        mon_en = 1'b1;
        for (int i = 0; i < 3; i++) tick(i == 2, code[i]);
        mon_en = 1'b0;
        tick(1, 1); tick(0, 1);
    endtask

    // Shift n bits of a DR from Idle, or resume from Pause-DR without capture.
    task automatic shift_dr(input int n, input logic [255:0] din, input logic [255:0] expv,
                            input string tag, input bit from_pause, input bit to_pause);
        if (from_pause) begin
            tick(1, 1); tick(0, 1);
        end else begin
            tick(1, 1); tick(0, 1); tick(0, 1);
        end
        for (int i = 0; i < n; i++) begin
            exp_bits.push_back(expv[i]);
            exp_tags.push_back(tag);
        end
        mon_en = 1'b1;
        for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
        mon_en = 1'b0;
        if (to_pause) begin
            tick(0, 1);
        end else begin
            tick(1, 1); tick(0, 1);
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [255:0] d;
        logic [255:0] e;
        logic [N-1:0] p;
        logic [N-1:0] q;

        tap_reset();
        // R1: reset leaves IDCODE active, so the data pins are not floated.
        check("R1 reset dq_hiz", {31'b0, dq_hiz}, 32'd0);
        check("R9 reset tdo_oe", {31'b0, tdo_oe}, 32'd0);
        tick(0, 1);

        // R6: ID word, followed by the TDI bits, proves its 32-bit length.
        d = '0; d[7:0] = 8'b1100_1010;
        e = '0; e[31:0] = ID_EXP; e[39:32] = d[7:0];
        shift_dr(40, d, e, "R6 ident word", 0, 0);

        // R9: TDO holds across the rising edge and moves on the falling edge.
        tick(1, 1); tick(0, 1); tick(0, 1);
        @(negedge tck); #1;
        check("R9 tdo first bit", {31'b0, tdo}, {31'b0, ID_EXP[0]});
        tick(0, 1);
        check("R9 tdo held over rising edge", {31'b0, tdo}, {31'b0, ID_EXP[0]});
        @(negedge tck); #1;
        check("R9 tdo after falling edge", {31'b0, tdo}, {31'b0, ID_EXP[1]});
        tick(1, 1); tick(1, 1); tick(0, 1);
        check("R9 tdo_oe idle", {31'b0, tdo_oe}, 32'd0);

        // R3/R4: load BYPASS; R7: capture 0 then a one-stage delay; hold through Pause.
        shift_ir(3'b111, "R3 ir capture");
        check("R5 bypass dq_hiz", {31'b0, dq_hiz}, 32'd0);
        d = '0; d[7:0] = 8'b1011_0010;
        e = '0; e[0] = 1'b0; e[7:1] = d[6:0];
        shift_dr(8, d, e, "R7 bypass delay", 0, 1);
        d = '0; d[1:0] = 2'b01;
        e = '0; e[0] = 1'b1; e[1] = 1'b1;
        shift_dr(2, d, e, "R7 bypass hold across pause", 1, 0);

        // R4: reserved codes select the bypass stage.
        for (int k = 0; k < 3; k++) begin
            logic [2:0] rc;
            rc = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            shift_ir(rc, "R3 ir capture");
            check("R4 reserved dq_hiz", {31'b0, dq_hiz}, 32'd0);
            d = '0; d[3:0] = 4'b1101;
            e = '0; e[3:1] = d[2:0];
            shift_dr(4, d, e, "R4 reserved selects bypass", 0, 0);
        end

        // R4/R8: SAMPLE captures the pins and leaves the data pins driven.
        for (int i = 0; i < N; i++) p[i] = (i % 3 == 0);
        pins = p;
        shift_ir(3'b100, "R3 ir capture");
        check("R5 sample dq_hiz", {31'b0, dq_hiz}, 32'd0);
        d = '0; e = '0; e[N-1:0] = p;
        shift_dr(N, d, e, "R8 sample pin capture", 0, 0);

        // R4/R5/R8: SAMPLE-Z floats the data pins; a second pass proves 109 bits.
        for (int i = 0; i < N; i++) begin p[i] = i[0] ^ i[3]; q[i] = (i % 5 == 1); end
        pins = p;
        shift_ir(3'b010, "R3 ir capture");
        check("R5 sample-z dq_hiz", {31'b0, dq_hiz}, 32'd1);
        d = '0; d[N-1:0] = q; e = '0; e[N-1:0] = p;
        shift_dr(N, d, e, "R8 sample-z pin capture", 0, 1);
        d = '0; e = '0; e[N-1:0] = q;
        shift_dr(N, d, e, "R8 chain length 109", 1, 0);

        // R4/R5: EXTEST floats the data pins and uses the boundary chain.
        p = ~p;
        pins = p;
        shift_ir(3'b000, "R3 ir capture");
        check("R5 extest dq_hiz", {31'b0, dq_hiz}, 32'd1);
        d = '0; e = '0; e[N-1:0] = p;
        shift_dr(N, d, e, "R8 extest pin capture", 0, 0);

        // R1: five TMS-high edges return to IDCODE.
        repeat (5) tick(1, 1);
        check("R1 five ones dq_hiz", {31'b0, dq_hiz}, 32'd0);
        tick(0, 1);
        d = '0; e = '0; e[31:0] = ID_EXP;
        shift_dr(32, d, e, "R1 ident after tms reset", 0, 0);

        // R1: power-on reset mid-run also restores IDCODE.
        shift_ir(3'b010, "R3 ir capture");
        check("R5 sample-z again dq_hiz", {31'b0, dq_hiz}, 32'd1);
        tap_reset();
        check("R1 por dq_hiz", {31'b0, dq_hiz}, 32'd0);
        tick(0, 1);
        shift_dr(32, d, e, "R1 ident after por", 0, 0);

        check("R2 scoreboard drained", exp_bits.size(), 0);
        finish_run();
    end

endmodule